// File: doc/BRIEF.md
# Wiper Register Instruction Engine

This block sits behind a serial bus front end and executes the commands for one 10-bit wiper register and four 10-bit retained data registers. The front end reports a frame start (with the read/write bit of the address byte), each received byte, each request for a byte to send, and a frame stop. The engine decodes the instruction byte, tells the two-byte copy commands apart from the four-byte read and write commands, and splits or joins the 10-bit value across two data bytes. Register updates happen only on a STOP that follows a complete command.

Writes into the data registers stand for nonvolatile programming. Each one holds `busy` high for a configurable number of cycles. While `busy` is high, new frames are ignored. A low write-protect input blocks every data-register update but still lets the wiper change. The wiper code drives a one-hot tap select, and after reset the wiper is recalled from data register 0.

The controller has nine named states. ST_RECALL is entered on reset and always moves to ST_IDLE. ST_IDLE goes to ST_OPCODE on a start when not busy. From ST_OPCODE, an instruction byte leads to ST_RD_HI for the two reads, to ST_WR_HI for the two writes, to ST_ARMED for the two copies, and to ST_DROP when the opcode is undefined. ST_RD_HI moves to ST_RD_LO on a send request, and ST_RD_LO moves to ST_ARMED on the next one. ST_WR_HI moves to ST_WR_LO on a byte, and ST_WR_LO moves to ST_ARMED on the next byte. ST_ARMED goes to ST_DROP on any surplus byte or request. ST_DROP waits for the frame to end. From any state, a start re-enters ST_OPCODE, or ST_IDLE while busy, and a stop returns to ST_IDLE; in ST_ARMED that stop executes the command.

Top module: `wiper_cmd_engine`

## Requirements
- R1: The instruction byte carries the opcode in bits 7:5, the register select in bits 3:2 (value 0 to 3 selects data register 0 to 3), and bits 4, 1 and 0 are not decoded. With frame_rw=1, opcode 100 reads the wiper: the first byte sent is {000000, code[9:8]} and the second is code[7:0].
- R2: With frame_rw=0, opcode 101 writes the wiper from two data bytes. Bits 1:0 of the first byte give code[9:8], its upper six bits are ignored, and the second byte gives code[7:0].
- R3: With frame_rw=1, opcode 101 reads the selected data register, using the same two-byte layout as R1.
- R4: With frame_rw=0, opcode 110 writes the selected data register, using the same two-byte layout as R2.
- R5: With frame_rw=1, opcode 110 copies the selected data register into the wiper. With frame_rw=0, opcode 111 copies the wiper into the selected data register. Both commands end after the instruction byte.
- R6: After reset the data registers hold DR_INIT, the wiper equals data register 0, and busy is low.
- R7: A data-register write or a wiper-to-register copy raises busy on the clock edge that takes STOP. Busy then stays high for exactly NV_CYCLES cycles. No other command raises busy.
- R8: While wp_n is low, data-register writes and copies change nothing and raise no busy. Wiper writes and register-to-wiper copies still execute.
- R9: A frame that starts while busy is high executes nothing.
- R10: A command changes a register only when STOP follows the complete command. A command cut short by a new START or by an early STOP is discarded.
- R11: An undefined frame_rw/opcode combination is accepted but executes nothing.
- R12: tap_sel has exactly one bit set, at the index equal to the wiper code. Code 000h sets bit 0 and code 3FFh sets bit 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse: START seen and address matched |
| frame_rw | input | 1 | Read/write bit of the address, valid with frame_start |
| rx_valid | input | 1 | One-cycle pulse: rx_byte holds a received byte |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | One-cycle pulse: front end has taken tx_byte and wants the next one |
| frame_stop | input | 1 | One-cycle pulse: STOP seen |
| wp_n | input | 1 | Write protect, low blocks data-register updates |
| tx_byte | output | 8 | Byte to send on a read |
| busy | output | 1 | Nonvolatile write in progress |
| wiper_code | output | 10 | Current wiper code |
| tap_sel | output | 1024 | One-hot tap select |

## Verification
Every input pulse is captured on one rising edge. The register that pulse updates (state, wiper, data register or busy timer) is visible right after that edge, so all results are due one cycle after the stimulus. The bench drives on falling edges and samples on the following falling edge. Read bytes are checked one cycle after the instruction byte and again one cycle after the first send request. The wiper and tap select are checked one cycle after STOP, or once busy has fallen. Busy length is measured by counting the falling edges at which busy is high, starting with the first one after the STOP pulse.

// File: rtl/wip_pkg.sv
package wip_pkg;
    localparam int CODE_W = 10;
    localparam int NUM_DR = 4;
    localparam int SEL_W  = $clog2(NUM_DR);
    localparam int TAPS   = 1 << CODE_W;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_RD_W,
        ACT_WR_W,
        ACT_RD_D,
        ACT_WR_D,
        ACT_D2W,
        ACT_W2D
    } act_e;

    typedef enum logic [3:0] {
        ST_RECALL,
        ST_IDLE,
        ST_OPCODE,
        ST_RD_HI,
        ST_RD_LO,
        ST_WR_HI,
        ST_WR_LO,
        ST_ARMED,
        ST_DROP
    } state_e;
endpackage

// File: rtl/wip_cmd_decode.sv
module wip_cmd_decode
    import wip_pkg::*;
(
    input  logic             rw,
    input  logic [2:0]       opcode,
    input  logic [SEL_W-1:0] sel_in,
    output act_e             act,
    output logic [SEL_W-1:0] sel
);
    always_comb begin
        sel = sel_in;
        case ({rw, opcode})
            4'b1100: act = ACT_RD_W;
            4'b1101: act = ACT_RD_D;
            4'b1110: act = ACT_D2W;
            4'b0101: act = ACT_WR_W;
            4'b0110: act = ACT_WR_D;
            4'b0111: act = ACT_W2D;
            default: act = ACT_NONE;
        endcase
    end
endmodule

// File: rtl/wip_nv_timer.sv
module wip_nv_timer #(
    parameter int NV_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(NV_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(NV_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/wip_tap_decode.sv
module wip_tap_decode
    import wip_pkg::*;
(
    input  code_t           code,
    output logic [TAPS-1:0] taps
);
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign taps[i] = (code == CODE_W'(i));
    end
endmodule

// File: rtl/wiper_cmd_engine.sv
module wiper_cmd_engine
    import wip_pkg::*;
#(
    parameter int                         NV_CYCLES = 500000,
    parameter logic [NUM_DR*CODE_W-1:0]   DR_INIT   = {10'h3FF, 10'h0AA, 10'h155, 10'h2C3}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              frame_rw,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              tx_req,
    input  logic              frame_stop,
    input  logic              wp_n,
    output logic [7:0]        tx_byte,
    output logic              busy,
    output logic [CODE_W-1:0] wiper_code,
    output logic [TAPS-1:0]   tap_sel
);
    localparam int HI_W = CODE_W - 8;

    state_e           state_q, state_d;
    logic             rw_q;
    act_e             act_q;
    logic [SEL_W-1:0] sel_q;
    code_t            wr_val_q;
    code_t            rd_val_q;
    code_t            wiper_q;
    code_t            dr_q [NUM_DR];

    act_e             dec_act;
    logic [SEL_W-1:0] dec_sel;
    logic             exec;
    logic             nv_start;

    wip_cmd_decode u_dec (
        .rw     (rw_q),
        .opcode (rx_byte[7:5]),
        .sel_in (rx_byte[3:2]),
        .act    (dec_act),
        .sel    (dec_sel)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RECALL;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (state_q == ST_RECALL) begin
            state_d = ST_IDLE;
        end else if (frame_start) begin
            state_d = busy ? ST_IDLE : ST_OPCODE;
        end else if (frame_stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_OPCODE: begin
                    if (rx_valid) begin
                        unique case (dec_act)
                            ACT_RD_W, ACT_RD_D: state_d = ST_RD_HI;
                            ACT_WR_W, ACT_WR_D: state_d = ST_WR_HI;
                            ACT_D2W,  ACT_W2D:  state_d = ST_ARMED;
                            default:            state_d = ST_DROP;
                        endcase
                    end
                end
                ST_RD_HI: if (tx_req)   state_d = ST_RD_LO;
                ST_RD_LO: if (tx_req)   state_d = ST_ARMED;
                ST_WR_HI: if (rx_valid) state_d = ST_WR_LO;
                ST_WR_LO: if (rx_valid) state_d = ST_ARMED;
                ST_ARMED: if (rx_valid || tx_req) state_d = ST_DROP;
                ST_DROP:  state_d = ST_DROP;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    assign exec     = frame_stop && !frame_start && (state_q == ST_ARMED);
    assign nv_start = exec && wp_n && ((act_q == ACT_WR_D) || (act_q == ACT_W2D));

    // Command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rw_q     <= 1'b0;
            act_q    <= ACT_NONE;
            sel_q    <= '0;
            wr_val_q <= '0;
            rd_val_q <= '0;
        end else begin
            if (frame_start) begin
                rw_q <= frame_rw;
            end
            if (state_q == ST_OPCODE && rx_valid && !frame_start && !frame_stop) begin
                act_q    <= dec_act;
                sel_q    <= dec_sel;
                rd_val_q <= (dec_act == ACT_RD_W) ? wiper_q : dr_q[dec_sel];
            end
            if (state_q == ST_WR_HI && rx_valid) begin
                wr_val_q[CODE_W-1:8] <= rx_byte[HI_W-1:0];
            end
            if (state_q == ST_WR_LO && rx_valid) begin
                wr_val_q[7:0] <= rx_byte;
            end
        end
    end

    // Wiper and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wiper_q <= '0;
            for (int i = 0; i < NUM_DR; i++) begin
                dr_q[i] <= DR_INIT[i*CODE_W +: CODE_W];
            end
        end else if (state_q == ST_RECALL) begin
            wiper_q <= dr_q[0];
        end else if (exec) begin
            unique case (act_q)
                ACT_WR_W: wiper_q <= wr_val_q;
                ACT_D2W:  wiper_q <= dr_q[sel_q];
                ACT_WR_D: if (wp_n) dr_q[sel_q] <= wr_val_q;
                ACT_W2D:  if (wp_n) dr_q[sel_q] <= wiper_q;
                default:  ;
            endcase
        end
    end

    wip_nv_timer #(.NV_CYCLES(NV_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (nv_start),
        .busy  (busy)
    );

    wip_tap_decode u_taps (
        .code (wiper_q),
        .taps (tap_sel)
    );

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_RD_HI: tx_byte = {{(8-HI_W){1'b0}}, rd_val_q[CODE_W-1:8]};
            ST_RD_LO: tx_byte = rd_val_q[7:0];
            default:  tx_byte = 8'h00;
        endcase
        wiper_code = wiper_q;
    end
endmodule

// File: rtl/wiper_cmd_engine_chk.sv
module wiper_cmd_engine_chk
    import wip_pkg::*;
#(
    parameter int NV_CYCLES = 500000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_stop,
    input logic              wp_n,
    input logic              busy,
    input logic [CODE_W-1:0] wiper_code,
    input logic [TAPS-1:0]   tap_sel
);
    localparam int RW = $clog2(NV_CYCLES + 2);

    logic          live_q;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= 1'b0;
            run_q  <= '0;
        end else begin
            live_q <= 1'b1;
            run_q  <= busy ? run_q + 1'b1 : '0;
        end
    end

    // R12
    tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(tap_sel) == 1) && tap_sel[wiper_code]);

    // R10
    wiper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !frame_stop) |=> $stable(wiper_code));

    // R8
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(frame_stop) && $past(wp_n)));

    // R7
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == RW'(NV_CYCLES)));

    // R9
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && busy) |=> $stable(wiper_code));
endmodule

bind wiper_cmd_engine wiper_cmd_engine_chk #(.NV_CYCLES(NV_CYCLES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_stop (frame_stop),
    .wp_n       (wp_n),
    .busy       (busy),
    .wiper_code (wiper_code),
    .tap_sel    (tap_sel)
);

// File: tb/wiper_cmd_engine_tb.sv
module wiper_cmd_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV         = 40;
    localparam int NVEC       = 15;

    // {rw, instr, value, wp_n, chk_read, exp_read, exp_wiper}
    localparam logic [40:0] VEC [NVEC] = '{
        {1'b0, 8'hA0, 10'h123, 1'b1, 1'b0, 10'h000, 10'h123}, // R2 write wiper
        {1'b1, 8'h80, 10'h000, 1'b1, 1'b1, 10'h123, 10'h123}, // R1 read wiper
        {1'b1, 8'hA8, 10'h000, 1'b1, 1'b1, 10'h0AA, 10'h123}, // R3 read dr2
        {1'b1, 8'hCC, 10'h000, 1'b1, 1'b0, 10'h000, 10'h3FF}, // R5 dr3->wiper
        {1'b0, 8'hC4, 10'h0F0, 1'b1, 1'b0, 10'h000, 10'h3FF}, // R4 write dr1
        {1'b1, 8'hA4, 10'h000, 1'b1, 1'b1, 10'h0F0, 10'h3FF}, // R4 read back dr1
        {1'b1, 8'hC4, 10'h000, 1'b1, 1'b0, 10'h000, 10'h0F0}, // R5 dr1->wiper
        {1'b0, 8'hA0, 10'h000, 1'b1, 1'b0, 10'h000, 10'h000}, // R12 code 000
        {1'b0, 8'hEC, 10'h000, 1'b1, 1'b0, 10'h000, 10'h000}, // R5 wiper->dr3
        {1'b1, 8'hAC, 10'h000, 1'b1, 1'b1, 10'h000, 10'h000}, // R5 read dr3
        {1'b0, 8'hC0, 10'h3AB, 1'b0, 1'b0, 10'h000, 10'h000}, // R8 protected write dr0
        {1'b1, 8'hA0, 10'h000, 1'b1, 1'b1, 10'h2C3, 10'h000}, // R8 dr0 unchanged
        {1'b0, 8'h80, 10'h000, 1'b1, 1'b0, 10'h000, 10'h000}, // R11 undefined rw0 100
        {1'b1, 8'hE0, 10'h000, 1'b1, 1'b0, 10'h000, 10'h000}, // R11 undefined rw1 111
        {1'b0, 8'hA0, 10'h3FF, 1'b0, 1'b0, 10'h000, 10'h3FF}  // R8 wiper under wp, R12 3FF
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_start = 1'b0;
    logic         frame_rw = 1'b0;
    logic         rx_valid = 1'b0;
    logic [7:0]   rx_byte = 8'h00;
    logic         tx_req = 1'b0;
    logic         frame_stop = 1'b0;
    logic         wp_n = 1'b1;
    logic [7:0]   tx_byte;
    logic         busy;
    logic [9:0]   wiper_code;
    logic [1023:0] tap_sel;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wiper_cmd_engine #(.NV_CYCLES(NV)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_rw(frame_rw),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req), .frame_stop(frame_stop),
        .wp_n(wp_n), .tx_byte(tx_byte), .busy(busy), .wiper_code(wiper_code), .tap_sel(tap_sel)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic rw);
        @(negedge clk); frame_start = 1'b1; frame_rw = rw;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic pulse_req();
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); frame_stop = 1'b1;
        @(negedge clk); frame_stop = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic check_wiper(input logic [9:0] exp, input string req);
        chk(wiper_code == exp, req, wiper_code, exp);
        chk(tap_sel[exp] && ($countones(tap_sel) == 1), "R12", $countones(tap_sel), 1);
    endtask

    task automatic run_cmd(input logic rw, input logic [7:0] instr, input logic [9:0] val,
                           input logic wp, input logic chk_rd, input logic [9:0] exp_rd,
                           input string req);
        wp_n = wp;
        pulse_start(rw);
        send_byte(instr);
        if (chk_rd) begin
            chk(tx_byte == {6'b000000, exp_rd[9:8]}, req, tx_byte, {6'b000000, exp_rd[9:8]});
            pulse_req();
            chk(tx_byte == exp_rd[7:0], req, tx_byte, exp_rd[7:0]);
            pulse_req();
        end
        if (!rw && (instr[7:5] == 3'b101 || instr[7:5] == 3'b110)) begin
            send_byte({6'b101010, val[9:8]});
            send_byte(val[7:0]);
        end
        pulse_stop();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int nbusy;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R6 reset state
        chk(busy == 1'b0, "R6", busy, 0);
        check_wiper(10'h2C3, "R6");

        for (int i = 0; i < NVEC; i++) begin
            logic [40:0] v;
            v = VEC[i];
            run_cmd(v[40], v[39:32], v[31:22], v[21], v[20], v[19:10], $sformatf("R1-vec%0d", i));
            wait_idle();
            check_wiper(v[9:0], $sformatf("R5 vec%0d", i));
        end

        // R7 busy length for a data-register write
        wp_n = 1'b1;
        pulse_start(1'b0);
        send_byte(8'hC8);
        send_byte(8'h01);
        send_byte(8'h11);
        pulse_stop();
        nbusy = 0;
        while (busy && nbusy < 1000) begin
            nbusy++;
            @(negedge clk);
        end
        chk(nbusy == NV, "R7", nbusy, NV);

        // R7 wiper write raises no busy
        run_cmd(1'b0, 8'hA0, 10'h055, 1'b1, 1'b0, 10'h0, "R7");
        chk(busy == 1'b0, "R7", busy, 0);
        check_wiper(10'h055, "R2");

        // R9 frame during busy is ignored
        run_cmd(1'b0, 8'hC8, 10'h222, 1'b1, 1'b0, 10'h0, "R4");
        chk(busy == 1'b1, "R7", busy, 1);
        run_cmd(1'b0, 8'hA0, 10'h1EE, 1'b1, 1'b0, 10'h0, "R9");
        wait_idle();
        check_wiper(10'h055, "R9");
        run_cmd(1'b1, 8'hA8, 10'h0, 1'b1, 1'b1, 10'h222, "R4");

        // R10 command cut short by a new START
        pulse_start(1'b0);
        send_byte(8'hA0);
        send_byte(8'h03);
        run_cmd(1'b1, 8'h80, 10'h0, 1'b1, 1'b1, 10'h055, "R10");
        check_wiper(10'h055, "R10");

        // R10 command ended by an early STOP
        pulse_start(1'b0);
        send_byte(8'hA0);
        send_byte(8'h02);
        pulse_stop();
        check_wiper(10'h055, "R10");

        // R6 recall after a second reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        check_wiper(10'h2C3, "R6");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule